// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs one read or one write transfer at a time on a 20-bit processor-style bus. On that bus the low sixteen lines carry first the address and then data, and the top four lines carry first the upper address bits and then cycle status. A request arrives as a single-cycle pulse while the block is idle. The pulse carries the address, a memory/I/O flag, a read/write flag, two byte-lane enables and the write data. The block then steps through the T1, T2, T3 and T4 states and adds wait states while the target holds `ready` low. It generates every strobe that external address latches, data transceivers and peripherals need.

The tri-state lines are modelled as three separate signals per line group: an output value, an output enable and, for the data lines, an input. All bus outputs come straight from flip-flops. When a read completes, `rsp_done` pulses for one cycle and the data appears on `rsp_rdata`, with byte lanes that were not enabled forced to zero.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: After reset, and whenever no cycle is in progress, `ad_oe` and `hi_oe` are low, `ale` is low, `rd_n`, `wr_n`, `den_n` and `bhe_n` are high, `m_io` and `dt_r` are low, `busy` is low and `rsp_done` is low. Reset also clears `rsp_rdata` to zero.
- R2: In T1, which is the first cycle after a request is accepted, `ale` is high for exactly that one cycle. In T1 `ad_out` carries address bits 15:0 with `ad_oe` high. `hi_out` carries address bits 19:16 for a memory cycle and zero for an I/O cycle, with `hi_oe` high. `bhe_n` is low exactly when byte enable bit 1 is set.
- R3: A cycle is T1, T2, T3, then one wait state for each consecutive low sample of `ready` taken at the clock edge that ends T3 or a wait state, then T4, then idle. `busy` is high from T1 through T4. `ready` is ignored in T1 and T2.
- R4: From T2 through T4, `hi_out` carries status with `hi_oe` high. Bit 0 is the memory flag, bit 1 the write flag, bit 2 byte enable bit 1, and bit 3 is zero. `bhe_n` is high during these states. `m_io` (1 = memory) and `dt_r` (1 = write) keep their value from T1 through T4.
- R5: In a read cycle, `ad_oe` is low from T2 through T4. `rd_n` and `den_n` are low in T2, T3 and every wait state, and both are high in T4. `wr_n` stays high.
- R6: In a write cycle, `ad_out` carries the write data with `ad_oe` high from T2 through T4. `wr_n` is low in T2, T3 and every wait state and high in T4. `den_n` is low from T2 through T4. `rd_n` stays high.
- R7: Read data is sampled from `ad_in` at the clock edge that ends the last T3 or wait state. Byte lane 0 is bits 7:0 and lane 1 is bits 15:8, and a lane whose enable bit is clear reads as zero. `rsp_done` is high for exactly the T4 cycle. `rsp_rdata` holds its value until the next read completes.
- R8: A request presented while a cycle is in progress is ignored. It neither changes the running cycle nor starts a new cycle after T4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pulse, accepted only when idle |
| req_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables (bit 0 low byte, bit 1 high byte) |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A cycle is in progress |
| rsp_done | output | 1 | One-cycle pulse in T4 |
| rsp_rdata | output | 16 | Last read data, masked by byte enables |
| ready | input | 1 | Target ready; low extends the cycle |
| ad_in | input | 16 | Value seen on the shared low lines |
| ad_out | output | 16 | Value driven on the shared low lines |
| ad_oe | output | 1 | Output enable of the shared low lines |
| hi_out | output | 4 | Upper address in T1, status afterwards |
| hi_oe | output | 1 | Output enable of the upper lines |
| bhe_n | output | 1 | Active-low upper-byte enable, valid in T1 |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Active-low transceiver enable |

## Verification
The bench sweeps every combination of memory/I/O, read/write, byte-enable pattern and zero to three wait states, and checks all bus pins in every state of each cycle. It places stale data on `ad_in` until the final sampling edge, so a design that captures read data one edge early, or that ignores `ready` and finishes too soon, returns the wrong word or pulses `rsp_done` in the wrong cycle. A design that leaves the upper address on I/O cycles, drives the low lines during a read, keeps `den_n` low in read T4 or mixes up the status bits fails the per-state pin comparison. Half of the cycles also present a new request while busy, so a design that accepts it shows `ale` high again after T4.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_e;

  function automatic logic is_data_phase(input bus_st_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    ready,
  output bus_st_e st_q,
  output bus_st_e st_d,
  output logic    accept
);

  assign accept = (st_q == ST_IDLE) && req_valid;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: st_d = req_valid ? ST_T1 : ST_IDLE;
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ST_T3;
      ST_T3:   st_d = ready ? ST_T4 : ST_TW;
      ST_TW:   st_d = ready ? ST_T4 : ST_TW;
      ST_T4:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/mbus_req_hold.sv
module mbus_req_hold #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              in_is_mem,
  input  logic              in_is_write,
  input  logic [LANES-1:0]  in_be,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              h_is_mem,
  output logic              h_is_write,
  output logic [LANES-1:0]  h_be,
  output logic [ADDR_W-1:0] h_addr,
  output logic [DATA_W-1:0] h_wdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_is_mem   <= 1'b0;
      h_is_write <= 1'b0;
      h_be       <= '0;
      h_addr     <= '0;
      h_wdata    <= '0;
    end else if (accept) begin
      h_is_mem   <= in_is_mem;
      h_is_write <= in_is_write;
      h_be       <= in_be;
      h_addr     <= in_addr;
      h_wdata    <= in_wdata;
    end
  end

endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int IO_W   = 16,
  localparam int LANES = DATA_W / 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_st_e           st_d,
  input  logic              s_is_mem,
  input  logic              s_is_write,
  input  logic [LANES-1:0]  s_be,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              hi_oe,
  output logic              bhe_n,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m_io,
  output logic              dt_r,
  output logic              den_n
);

  localparam logic [ADDR_W-1:0] IO_MASK = ADDR_W'((64'd1 << IO_W) - 64'd1);

  logic [ADDR_W-1:0] eff_addr;
  logic [HI_W-1:0]   status;

  assign eff_addr = s_is_mem ? s_addr : (s_addr & IO_MASK);

  always_comb begin
    status    = '0;
    status[0] = s_is_mem;
    status[1] = s_is_write;
    status[2] = s_be[LANES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out <= '0;
      ad_oe  <= 1'b0;
      hi_out <= '0;
      hi_oe  <= 1'b0;
      bhe_n  <= 1'b1;
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      m_io   <= 1'b0;
      dt_r   <= 1'b0;
      den_n  <= 1'b1;
    end else begin
      case (st_d)
        ST_T1: begin
          ad_out <= eff_addr[DATA_W-1:0];
          ad_oe  <= 1'b1;
          hi_out <= eff_addr[ADDR_W-1:DATA_W];
          hi_oe  <= 1'b1;
          bhe_n  <= ~s_be[LANES-1];
          ale    <= 1'b1;
          rd_n   <= 1'b1;
          wr_n   <= 1'b1;
          m_io   <= s_is_mem;
          dt_r   <= s_is_write;
          den_n  <= 1'b1;
        end
        ST_T2, ST_T3, ST_TW: begin
          ad_out <= s_is_write ? s_wdata : '0;
          ad_oe  <= s_is_write;
          hi_out <= status;
          hi_oe  <= 1'b1;
          bhe_n  <= 1'b1;
          ale    <= 1'b0;
          rd_n   <= s_is_write;
          wr_n   <= ~s_is_write;
          m_io   <= s_is_mem;
          dt_r   <= s_is_write;
          den_n  <= 1'b0;
        end
        ST_T4: begin
          ad_out <= s_is_write ? s_wdata : '0;
          ad_oe  <= s_is_write;
          hi_out <= status;
          hi_oe  <= 1'b1;
          bhe_n  <= 1'b1;
          ale    <= 1'b0;
          rd_n   <= 1'b1;
          wr_n   <= 1'b1;
          m_io   <= s_is_mem;
          dt_r   <= s_is_write;
          den_n  <= ~s_is_write;
        end
        default: begin
          ad_out <= '0;
          ad_oe  <= 1'b0;
          hi_out <= '0;
          hi_oe  <= 1'b0;
          bhe_n  <= 1'b1;
          ale    <= 1'b0;
          rd_n   <= 1'b1;
          wr_n   <= 1'b1;
          m_io   <= 1'b0;
          dt_r   <= 1'b0;
          den_n  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/mbus_rd_capture.sv
module mbus_rd_capture
  import mbus_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_st_e           st_q,
  input  bus_st_e           st_d,
  input  logic              h_is_write,
  input  logic [LANES-1:0]  h_be,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done
);

  logic              last_edge;
  logic [DATA_W-1:0] masked;

  assign last_edge = (st_d == ST_T4) && (st_q != ST_T4);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign masked[g*8 +: 8] = h_be[g] ? ad_in[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      rsp_done <= last_edge;
      if (last_edge && !h_is_write) rsp_rdata <= masked;
    end
  end

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int IO_W   = 16,
  localparam int LANES = DATA_W / 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_mem,
  input  logic              req_is_write,
  input  logic [LANES-1:0]  req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ready,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              hi_oe,
  output logic              bhe_n,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m_io,
  output logic              dt_r,
  output logic              den_n
);

  bus_st_e           st_q, st_d;
  logic              accept;
  logic              h_is_mem, h_is_write;
  logic [LANES-1:0]  h_be;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic              s_is_mem, s_is_write;
  logic [LANES-1:0]  s_be;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;

  mbus_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready),
    .st_q(st_q), .st_d(st_d), .accept(accept)
  );

  mbus_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .accept(accept),
    .in_is_mem(req_is_mem), .in_is_write(req_is_write), .in_be(req_be),
    .in_addr(req_addr), .in_wdata(req_wdata),
    .h_is_mem(h_is_mem), .h_is_write(h_is_write), .h_be(h_be),
    .h_addr(h_addr), .h_wdata(h_wdata)
  );

  // The accepted request steers T1 directly; later states use the held copy.
  assign s_is_mem   = accept ? req_is_mem   : h_is_mem;
  assign s_is_write = accept ? req_is_write : h_is_write;
  assign s_be       = accept ? req_be       : h_be;
  assign s_addr     = accept ? req_addr     : h_addr;
  assign s_wdata    = accept ? req_wdata    : h_wdata;

  mbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_W(IO_W)) u_pins (
    .clk(clk), .rst(rst), .st_d(st_d),
    .s_is_mem(s_is_mem), .s_is_write(s_is_write), .s_be(s_be),
    .s_addr(s_addr), .s_wdata(s_wdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out), .hi_oe(hi_oe),
    .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .m_io(m_io), .dt_r(dt_r), .den_n(den_n)
  );

  mbus_rd_capture #(.DATA_W(DATA_W)) u_rcap (
    .clk(clk), .rst(rst), .st_q(st_q), .st_d(st_d),
    .h_is_write(h_is_write), .h_be(h_be), .ad_in(ad_in),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
  );

  assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/mbus_cycle_chk.sv
module mbus_cycle_chk
  import mbus_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input bus_st_e st,
  input logic    ready,
  input logic    ad_oe,
  input logic    hi_oe,
  input logic    ale,
  input logic    rd_n,
  input logic    wr_n,
  input logic    den_n,
  input logic    dt_r,
  input logic    rsp_done
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (!ad_oe && !hi_oe && rd_n && wr_n && den_n && !ale));

  a_r2_ale_pulse: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  a_r2_ale_addr: assert property (@(posedge clk) disable iff (rst)
    ale |-> (ad_oe && hi_oe && rd_n && wr_n));

  a_r3_wait_ext: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_T3 || st == ST_TW) && !ready) |=> (st == ST_TW));

  a_r3_wait_end: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_T3 || st == ST_TW) && ready) |=> (st == ST_T4));

  a_r5_rd_release: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (!ad_oe && !den_n && !dt_r && wr_n));

  a_r6_wr_drive: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (ad_oe && !den_n && dt_r && rd_n));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T4) |=> (st == ST_IDLE));

endmodule

bind mbus_cycle_ctrl mbus_cycle_chk u_chk (
  .clk(clk), .rst(rst), .st(st_q), .ready(ready),
  .ad_oe(ad_oe), .hi_oe(hi_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .den_n(den_n), .dt_r(dt_r), .rsp_done(rsp_done)
);

// File: tb/tb_mbus_cycle_ctrl.sv
module tb_mbus_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_is_mem = 1'b0;
  logic        req_is_write = 1'b0;
  logic [1:0]  req_be = 2'b00;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, rsp_done;
  logic [15:0] rsp_rdata;
  logic        ready = 1'b0;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  hi_out;
  logic        hi_oe, bhe_n, ale, rd_n, wr_n, m_io, dt_r, den_n;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mbus_cycle_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_mem(req_is_mem),
    .req_is_write(req_is_write), .req_be(req_be), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .ready(ready), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .hi_out(hi_out), .hi_oe(hi_oe), .bhe_n(bhe_n), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r), .den_n(den_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Control vector: {ale, rd_n, wr_n, den_n, dt_r, m_io, bhe_n, ad_oe, hi_oe}
  function automatic logic [8:0] ctl();
    return {ale, rd_n, wr_n, den_n, dt_r, m_io, bhe_n, ad_oe, hi_oe};
  endfunction

  localparam logic [8:0] IDLE_CTL = 9'b0_1_1_1_0_0_1_0_0;

  task automatic run_cycle(input bit mem, input bit wr, input logic [1:0] be,
                           input logic [19:0] addr, input logic [15:0] wd,
                           input logic [15:0] rd, input int waits, input bit poke);
    logic [3:0]  st_exp;
    logic [15:0] rd_exp;
    st_exp = {1'b0, be[1], wr, mem};
    rd_exp = {be[1] ? rd[15:8] : 8'h00, be[0] ? rd[7:0] : 8'h00};
    @(negedge clk);
    req_valid = 1'b1; req_is_mem = mem; req_is_write = wr; req_be = be;
    req_addr = addr; req_wdata = wd; ready = 1'b0; ad_in = ~rd;
    @(negedge clk);                      // T1
    req_valid = 1'b0;
    chk("R2 T1 controls", 32'(ctl()), 32'({1'b1, 1'b1, 1'b1, 1'b1, wr, mem, ~be[1], 1'b1, 1'b1}));
    chk("R2 T1 low address", 32'(ad_out), 32'(addr[15:0]));
    chk("R2 T1 upper address", 32'(hi_out), 32'(mem ? addr[19:16] : 4'h0));
    chk("R3 busy in T1", 32'(busy), 32'd1);
    if (poke) begin
      req_valid = 1'b1; req_addr = ~addr; req_is_write = ~wr; req_is_mem = ~mem;
      req_wdata = ~wd; req_be = ~be;
    end
    @(negedge clk);                      // T2
    chk(wr ? "R6 T2 controls" : "R5 T2 controls", 32'(ctl()),
        32'({1'b0, wr, ~wr, 1'b0, wr, mem, 1'b1, wr, 1'b1}));
    chk("R4 T2 status", 32'(hi_out), 32'(st_exp));
    if (wr) chk("R6 T2 write data", 32'(ad_out), 32'(wd));
    chk("R7 no done in T2", 32'(rsp_done), 32'd0);
    for (int k = 0; k <= waits; k++) begin
      @(negedge clk);                    // T3 when k == 0, wait states after
      chk(wr ? "R6 T3/TW controls" : "R5 T3/TW controls", 32'(ctl()),
          32'({1'b0, wr, ~wr, 1'b0, wr, mem, 1'b1, wr, 1'b1}));
      chk("R4 T3/TW status", 32'(hi_out), 32'(st_exp));
      chk("R3 no done before T4", 32'(rsp_done), 32'd0);
      if (wr) chk("R6 T3/TW write data", 32'(ad_out), 32'(wd));
      ready = (k >= waits);
      if (k == waits) ad_in = rd;
    end
    @(negedge clk);                      // T4
    ad_in = rd ^ 16'h5AA5;
    chk(wr ? "R6 T4 controls" : "R5 T4 controls", 32'(ctl()),
        32'({1'b0, 1'b1, 1'b1, ~wr, wr, mem, 1'b1, wr, 1'b1}));
    chk("R7 done in T4", 32'(rsp_done), 32'd1);
    chk("R4 T4 status", 32'(hi_out), 32'(st_exp));
    chk("R3 busy in T4", 32'(busy), 32'd1);
    if (wr) chk("R6 T4 write data", 32'(ad_out), 32'(wd));
    else    chk("R7 read data", 32'(rsp_rdata), 32'(rd_exp));
    @(negedge clk);                      // back to idle
    req_valid = 1'b0;
    chk(poke ? "R8 busy request ignored" : "R1 idle controls", 32'(ctl()), 32'(IDLE_CTL));
    chk("R3 not busy after T4", 32'(busy), 32'd0);
    chk("R7 done one cycle", 32'(rsp_done), 32'd0);
    if (!wr) chk("R7 read data held", 32'(rsp_rdata), 32'(rd_exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset controls", 32'(ctl()), 32'(IDLE_CTL));
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R1 reset done", 32'(rsp_done), 32'd0);
    chk("R1 reset rdata", 32'(rsp_rdata), 32'd0);
    for (int i = 0; i < 64; i++) begin
      logic [5:0] ix;
      ix = 6'(i);
      run_cycle(ix[5], ix[4], ix[3:2],
                20'(32'h3A5C7 + i * 32'h1F0D3),
                16'(i * 16'h1357) ^ 16'hA0F5,
                16'(i * 16'h2E71 + 16'h0C3B),
                int'(ix[1:0]), ix[0] ^ ix[2]);
    end
    // Requests arriving late in a long cycle are ignored too.
    run_cycle(1'b1, 1'b0, 2'b11, 20'hFFFFF, 16'h0000, 16'hFFFF, 3, 1'b1);
    run_cycle(1'b0, 1'b1, 2'b00, 20'hF0001, 16'h8001, 16'h0000, 0, 1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule